// File: doc/BRIEF.md
# Transfer Address and Count Update Unit

This block works out the next state of one transfer descriptor each time a data unit has moved. The surrounding controller presents the descriptor as it stands (counting mode, unit size, how each address moves, which address is the repeat area, the running transfer count, the programmed reload value, the block count and the two start addresses) and pulses a step input. One clock later the block presents the updated source and destination addresses, the updated counts, and flags that say whether a block or repeat cycle just closed, whether the whole transfer has ended, whether an interrupt should be raised and whether the next descriptor in a chain should run.

Three counting modes are supported. Normal mode counts down a 16-bit total and stops. Repeat mode counts a short cycle of 1 to 256 units, then reloads and snaps the repeat-area address back to its start, and never ends. Block mode also counts a 1 to 256 unit cycle, but each closed cycle consumes one entry of a 16-bit block count, and the transfer ends with the last block. A count field of zero always stands for the largest value its width can express. A descriptor whose addresses do not sit on a unit boundary is rejected: the error output rises and the descriptor comes back unchanged.

Top module: `xfer_desc_update`

## Requirements
- R1: Unit size code 0, 1 and 2 select 1, 2 and 4 bytes. Address mode code 1 adds one unit, code 2 subtracts one unit, codes 0 and 3 leave the address unchanged; arithmetic wraps modulo 2^32 with no error.
- R2: Mode code 0 (and the unused code 3) is normal mode: the 16-bit count output is the count input minus one (0 gives 65535), and end of transfer is flagged when the count input is 1; end of block is never flagged.
- R3: Mode code 1 is repeat mode: only the low 8 bits of the count are used, with 0 standing for 256. When they equal 1, the count output becomes the 8-bit reload value, the repeat-area address becomes its start address, end of block is flagged; otherwise the count output is the 8-bit value minus one. End of transfer is never flagged.
- R4: Mode code 2 is block mode: the 8-bit unit count behaves as in repeat mode, and on the last unit of a block the repeat-area address returns to its start while the other address advances normally.
- R5: In block mode the 16-bit block count decrements only on the last unit of a block (0 gives 65535, standing for 65536 blocks), and end of transfer is flagged when that last unit meets a block count of 1.
- R6: The repeat-area select (1 = destination, 0 = source) has no effect in normal mode.
- R7: With interrupt-each set, an interrupt is flagged on every unit in normal and repeat mode and on every closed block in block mode.
- R8: With interrupt-each clear, an interrupt is flagged at end of transfer in normal mode, at each reload in repeat mode, and at the last block in block mode.
- R9: Chain code 1 flags a chain step on every accepted unit, code 2 only at end of transfer, codes 0 and 3 never.
- R10: Unit size code 3, or a source or destination address not a multiple of the unit size, raises the error output; addresses and counts are returned unchanged and the end, block, interrupt and chain flags stay low.
- R11: Results and the done pulse appear on the clock edge that samples the step input; without a step, done is low and all other outputs hold.
- R12: Synchronous reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One data unit has moved; update the descriptor |
| mode_i | input | 2 | Counting mode: 0 normal, 1 repeat, 2 block, 3 normal |
| usize_i | input | 2 | Unit size: 0 byte, 1 two bytes, 2 four bytes, 3 invalid |
| src_am_i | input | 2 | Source address mode: 1 increment, 2 decrement, else fixed |
| dst_am_i | input | 2 | Destination address mode: 1 increment, 2 decrement, else fixed |
| rpt_dst_i | input | 1 | Repeat area: 1 destination, 0 source |
| irq_each_i | input | 1 | Interrupt on every unit or block rather than at the end |
| chain_i | input | 2 | Chain policy: 1 every unit, 2 at end, else none |
| src_addr_i | input | ADDR_W | Current source address |
| dst_addr_i | input | ADDR_W | Current destination address |
| src_init_i | input | ADDR_W | Start address of the source |
| dst_init_i | input | ADDR_W | Start address of the destination |
| cnt_i | input | CNT_W | Current transfer count |
| reload_i | input | RPT_W | Programmed repeat or block length |
| blk_i | input | CNT_W | Current block count |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Step rejected for alignment or size |
| eob_o | output | 1 | A repeat cycle or block closed |
| eot_o | output | 1 | The transfer ended |
| irq_o | output | 1 | Interrupt due |
| chain_o | output | 1 | Chain step due |
| src_next_o | output | ADDR_W | Updated source address |
| dst_next_o | output | ADDR_W | Updated destination address |
| cnt_next_o | output | CNT_W | Updated transfer count |
| blk_next_o | output | CNT_W | Updated block count |

## Verification
The block holds no state beyond its result register, so any fault in the update logic shows at the outputs on the very step that exercises it: a wrong stride or a missed snap-back gives a wrong address, a wrong zero encoding gives a count off by one wrap, and a misplaced end or reload shows as a flag on the wrong step. The bench therefore sweeps every mode, unit size, address-mode pair and repeat-area select against descriptors chosen at the count and address boundaries (count 1, count 0 as the maximum, addresses at 0 and at the top), and then feeds results back in for short multi-step runs so the reload and block-end sequence is seen in order.

// File: rtl/xdu_pkg.sv
package xdu_pkg;

    typedef enum logic [1:0] {
        XM_NORMAL = 2'd0,
        XM_REPEAT = 2'd1,
        XM_BLOCK  = 2'd2,
        XM_SPARE  = 2'd3
    } xdu_mode_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } xdu_am_e;

    typedef enum logic [1:0] {
        US_BYTE = 2'd0,
        US_HALF = 2'd1,
        US_WORD = 2'd2,
        US_BAD  = 2'd3
    } xdu_usize_e;

    typedef enum logic [1:0] {
        CH_NONE = 2'd0,
        CH_EACH = 2'd1,
        CH_LAST = 2'd2,
        CH_OFF  = 2'd3
    } xdu_chain_e;

    typedef struct packed {
        logic err;
        logic wrap;
        logic last;
        logic irq;
        logic chain;
    } xdu_flags_t;

    localparam int XDU_STRIDE_W = 3;

    function automatic logic [XDU_STRIDE_W-1:0] unit_bytes(xdu_usize_e s);
        unique case (s)
            US_BYTE: return 3'd1;
            US_HALF: return 3'd2;
            US_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic is_cyclic(xdu_mode_e m);
        return (m == XM_REPEAT) || (m == XM_BLOCK);
    endfunction

endpackage

// File: rtl/xdu_align_check.sv
module xdu_align_check
    import xdu_pkg::*;
(
    input  xdu_usize_e usize,
    input  logic [1:0] lsb,
    output logic       ok
);
    always_comb begin
        unique case (usize)
            US_BYTE: ok = 1'b1;
            US_HALF: ok = (lsb[0] == 1'b0);
            US_WORD: ok = (lsb == 2'b00);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/xdu_addr_unit.sv
module xdu_addr_unit
    import xdu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] init,
    input  xdu_am_e           am,
    input  xdu_usize_e        usize,
    input  logic              snap,
    output logic [ADDR_W-1:0] next
);
    localparam int PAD_W = ADDR_W - XDU_STRIDE_W;

    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] moved;

    assign stride = {{PAD_W{1'b0}}, unit_bytes(usize)};

    always_comb begin
        unique case (am)
            AM_INC:  moved = addr + stride;
            AM_DEC:  moved = addr - stride;
            default: moved = addr;
        endcase
        next = snap ? init : moved;
    end
endmodule

// File: rtl/xdu_count_unit.sv
module xdu_count_unit
    import xdu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RPT_W = 8
) (
    input  xdu_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [RPT_W-1:0] reload,
    input  logic [CNT_W-1:0] blk,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] blk_next,
    output logic             wrap,
    output logic             last
);
    localparam int                EXT_W = CNT_W - RPT_W;
    localparam logic [CNT_W-1:0]  ONE_L = CNT_W'(1);
    localparam logic [RPT_W-1:0]  ONE_S = RPT_W'(1);

    logic [RPT_W-1:0] short_cnt;
    logic [RPT_W-1:0] short_dec;
    logic             short_one;
    logic             long_one;
    logic             blk_one;

    assign short_cnt = cnt[RPT_W-1:0];
    assign short_dec = short_cnt - ONE_S;
    assign short_one = (short_cnt == ONE_S);
    assign long_one  = (cnt == ONE_L);
    assign blk_one   = (blk == ONE_L);

    always_comb begin
        cnt_next = cnt - ONE_L;
        blk_next = blk;
        wrap     = 1'b0;
        last     = 1'b0;
        unique case (mode)
            XM_REPEAT: begin
                wrap     = short_one;
                cnt_next = short_one ? {{EXT_W{1'b0}}, reload}
                                     : {{EXT_W{1'b0}}, short_dec};
            end
            XM_BLOCK: begin
                wrap     = short_one;
                cnt_next = short_one ? {{EXT_W{1'b0}}, reload}
                                     : {{EXT_W{1'b0}}, short_dec};
                blk_next = short_one ? (blk - ONE_L) : blk;
                last     = short_one && blk_one;
            end
            default: begin
                last = long_one;
            end
        endcase
    end
endmodule

// File: rtl/xdu_event_unit.sv
module xdu_event_unit
    import xdu_pkg::*;
(
    input  xdu_mode_e  mode,
    input  logic       irq_each,
    input  xdu_chain_e chain,
    input  logic       wrap,
    input  logic       last,
    output logic       irq,
    output logic       chain_due
);
    always_comb begin
        unique case (mode)
            XM_REPEAT: irq = irq_each || wrap;
            XM_BLOCK:  irq = wrap && (irq_each || last);
            default:   irq = irq_each || last;
        endcase
        unique case (chain)
            CH_EACH: chain_due = 1'b1;
            CH_LAST: chain_due = last;
            default: chain_due = 1'b0;
        endcase
    end
endmodule

// File: rtl/xfer_desc_update.sv
module xfer_desc_update
    import xdu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int RPT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        usize_i,
    input  logic [1:0]        src_am_i,
    input  logic [1:0]        dst_am_i,
    input  logic              rpt_dst_i,
    input  logic              irq_each_i,
    input  logic [1:0]        chain_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [ADDR_W-1:0] src_init_i,
    input  logic [ADDR_W-1:0] dst_init_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [RPT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  blk_i,
    output logic              done_o,
    output logic              err_o,
    output logic              eob_o,
    output logic              eot_o,
    output logic              irq_o,
    output logic              chain_o,
    output logic [ADDR_W-1:0] src_next_o,
    output logic [ADDR_W-1:0] dst_next_o,
    output logic [CNT_W-1:0]  cnt_next_o,
    output logic [CNT_W-1:0]  blk_next_o
);
    localparam int NADDR = 2;

    xdu_mode_e  mode;
    xdu_usize_e usize;

    assign mode  = xdu_mode_e'(mode_i);
    assign usize = xdu_usize_e'(usize_i);

    logic [ADDR_W-1:0] a_cur  [NADDR];
    logic [ADDR_W-1:0] a_init [NADDR];
    logic [ADDR_W-1:0] a_nxt  [NADDR];
    logic [1:0]        a_mode [NADDR];
    logic [NADDR-1:0]  a_ok;

    assign a_cur[0]  = src_addr_i;
    assign a_cur[1]  = dst_addr_i;
    assign a_init[0] = src_init_i;
    assign a_init[1] = dst_init_i;
    assign a_mode[0] = src_am_i;
    assign a_mode[1] = dst_am_i;

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] blk_nxt;
    logic             wrap;
    logic             last;
    logic             irq_due;
    logic             chain_due;
    logic             rejected;

    xdu_count_unit #(
        .CNT_W (CNT_W),
        .RPT_W (RPT_W)
    ) u_count (
        .mode     (mode),
        .cnt      (cnt_i),
        .reload   (reload_i),
        .blk      (blk_i),
        .cnt_next (cnt_nxt),
        .blk_next (blk_nxt),
        .wrap     (wrap),
        .last     (last)
    );

    generate
        for (genvar g = 0; g < NADDR; g++) begin : g_addr
            localparam bit IS_DST = (g == 1);
            logic snap;

            assign snap = wrap && is_cyclic(mode) && (rpt_dst_i == IS_DST);

            xdu_align_check u_align (
                .usize (usize),
                .lsb   (a_cur[g][1:0]),
                .ok    (a_ok[g])
            );

            xdu_addr_unit #(
                .ADDR_W (ADDR_W)
            ) u_adv (
                .addr  (a_cur[g]),
                .init  (a_init[g]),
                .am    (xdu_am_e'(a_mode[g])),
                .usize (usize),
                .snap  (snap),
                .next  (a_nxt[g])
            );
        end
    endgenerate

    xdu_event_unit u_event (
        .mode      (mode),
        .irq_each  (irq_each_i),
        .chain     (xdu_chain_e'(chain_i)),
        .wrap      (wrap),
        .last      (last),
        .irq       (irq_due),
        .chain_due (chain_due)
    );

    assign rejected = ~&a_ok;

    xdu_flags_t        flags_d;
    xdu_flags_t        flags_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  blk_q;
    logic              done_q;

    always_comb begin
        flags_d.err   = rejected;
        flags_d.wrap  = wrap      && !rejected;
        flags_d.last  = last      && !rejected;
        flags_d.irq   = irq_due   && !rejected;
        flags_d.chain = chain_due && !rejected;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            flags_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            blk_q   <= '0;
        end else begin
            done_q <= step_i;
            if (step_i) begin
                flags_q <= flags_d;
                if (rejected) begin
                    src_q <= src_addr_i;
                    dst_q <= dst_addr_i;
                    cnt_q <= cnt_i;
                    blk_q <= blk_i;
                end else begin
                    src_q <= a_nxt[0];
                    dst_q <= a_nxt[1];
                    cnt_q <= cnt_nxt;
                    blk_q <= blk_nxt;
                end
            end
        end
    end

    assign done_o     = done_q;
    assign err_o      = flags_q.err;
    assign eob_o      = flags_q.wrap;
    assign eot_o      = flags_q.last;
    assign irq_o      = flags_q.irq;
    assign chain_o    = flags_q.chain;
    assign src_next_o = src_q;
    assign dst_next_o = dst_q;
    assign cnt_next_o = cnt_q;
    assign blk_next_o = blk_q;
endmodule

// File: rtl/xfer_desc_update_chk.sv
module xfer_desc_update_chk
    import xdu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              step_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        src_am_i,
    input logic [ADDR_W-1:0] src_addr_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              done_o,
    input logic              err_o,
    input logic              eob_o,
    input logic              eot_o,
    input logic              irq_o,
    input logic [ADDR_W-1:0] src_next_o,
    input logic [CNT_W-1:0]  cnt_next_o
);
    AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        step_i |=> done_o); // R11

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> !done_o); // R11

    AST_REJECT_ECHOES: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (src_next_o == $past(src_addr_i)) && !irq_o && !eot_o && !eob_o); // R10

    AST_REPEAT_ENDLESS: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(mode_i) == XM_REPEAT) |-> !eot_o); // R3

    AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (done_o && eot_o) |-> irq_o); // R8

    AST_NORMAL_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o && $past(mode_i) != XM_REPEAT && $past(mode_i) != XM_BLOCK)
        |-> (cnt_next_o == CNT_W'($past(cnt_i) - 1'b1)) && !eob_o); // R2

    AST_FIXED_SRC_STILL: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o && $past(mode_i) == XM_NORMAL && $past(src_am_i) == AM_FIXED)
        |-> src_next_o == $past(src_addr_i)); // R1
endmodule

bind xfer_desc_update xfer_desc_update_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .mode_i     (mode_i),
    .src_am_i   (src_am_i),
    .src_addr_i (src_addr_i),
    .cnt_i      (cnt_i),
    .done_o     (done_o),
    .err_o      (err_o),
    .eob_o      (eob_o),
    .eot_o      (eot_o),
    .irq_o      (irq_o),
    .src_next_o (src_next_o),
    .cnt_next_o (cnt_next_o)
);

// File: tb/xfer_desc_update_tb_top.sv
module xfer_desc_update_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  usize_i = '0;
    logic [1:0]  src_am_i = '0;
    logic [1:0]  dst_am_i = '0;
    logic        rpt_dst_i = 1'b0;
    logic        irq_each_i = 1'b0;
    logic [1:0]  chain_i = '0;
    logic [31:0] src_addr_i = '0;
    logic [31:0] dst_addr_i = '0;
    logic [31:0] src_init_i = 32'hAAAA_0000;
    logic [31:0] dst_init_i = 32'h5555_0000;
    logic [15:0] cnt_i = '0;
    logic [7:0]  reload_i = '0;
    logic [15:0] blk_i = '0;

    logic        done_o, err_o, eob_o, eot_o, irq_o, chain_o;
    logic [31:0] src_next_o, dst_next_o;
    logic [15:0] cnt_next_o, blk_next_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xfer_desc_update dut_i (
        .clk (clk), .rst (rst), .step_i (step_i), .mode_i (mode_i),
        .usize_i (usize_i), .src_am_i (src_am_i), .dst_am_i (dst_am_i),
        .rpt_dst_i (rpt_dst_i), .irq_each_i (irq_each_i), .chain_i (chain_i),
        .src_addr_i (src_addr_i), .dst_addr_i (dst_addr_i),
        .src_init_i (src_init_i), .dst_init_i (dst_init_i),
        .cnt_i (cnt_i), .reload_i (reload_i), .blk_i (blk_i),
        .done_o (done_o), .err_o (err_o), .eob_o (eob_o), .eot_o (eot_o),
        .irq_o (irq_o), .chain_o (chain_o),
        .src_next_o (src_next_o), .dst_next_o (dst_next_o),
        .cnt_next_o (cnt_next_o), .blk_next_o (blk_next_o)
    );

    // expected values
    logic [31:0] e_src, e_dst;
    logic [15:0] e_cnt, e_blk;
    logic        e_err, e_eob, e_eot, e_irq, e_chain;

    task automatic chk(input string tag, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (mode %0d size %0d sam %0d dam %0d rsel %0d)",
                     tag, nm, act, exp, mode_i, usize_i, src_am_i, dst_am_i, rpt_dst_i);
        end
    endtask

    function automatic logic [31:0] move(logic [31:0] a, logic [1:0] am, int unsigned u);
        if (am == 2'd1) return a + u;
        if (am == 2'd2) return a - u;
        return a;
    endfunction

    task automatic predict();
        int unsigned unit;
        int unsigned s_eff;
        int unsigned b_eff;
        int unsigned n_eff;
        bit          bad;
        bit          unit_end;
        unit = (usize_i == 0) ? 1 : (usize_i == 1) ? 2 : (usize_i == 2) ? 4 : 0;
        if (unit == 0) bad = 1'b1;
        else bad = ((src_addr_i % unit) != 0) || ((dst_addr_i % unit) != 0);
        e_err = bad;
        e_eob = 0; e_eot = 0; e_irq = 0; e_chain = 0;
        e_src = src_addr_i; e_dst = dst_addr_i; e_cnt = cnt_i; e_blk = blk_i;
        if (!bad) begin
            unit_end = 0;
            if (mode_i == 2'd1 || mode_i == 2'd2) begin
                s_eff = cnt_i % 256;
                if (s_eff == 0) s_eff = 256;
                unit_end = (s_eff == 1);
                e_cnt = unit_end ? 16'(reload_i) : 16'(s_eff - 1);
                e_eob = unit_end;
                if (mode_i == 2'd2 && unit_end) begin
                    b_eff = (blk_i == 0) ? 65536 : blk_i;
                    e_blk = 16'(b_eff - 1);
                    e_eot = (b_eff == 1);
                end
            end else begin
                n_eff = (cnt_i == 0) ? 65536 : cnt_i;
                e_cnt = 16'(n_eff - 1);
                e_eot = (n_eff == 1);
            end
            e_src = move(src_addr_i, src_am_i, unit);
            e_dst = move(dst_addr_i, dst_am_i, unit);
            if (unit_end && rpt_dst_i)  e_dst = dst_init_i;
            if (unit_end && !rpt_dst_i) e_src = src_init_i;
            if (mode_i == 2'd1)      e_irq = irq_each_i || unit_end;
            else if (mode_i == 2'd2) e_irq = unit_end && (irq_each_i || e_eot);
            else                     e_irq = irq_each_i || e_eot;
            e_chain = (chain_i == 2'd1) ? 1'b1 : (chain_i == 2'd2) ? e_eot : 1'b0;
        end
    endtask

    task automatic step_and_check();
        string ta, tc, te, ti;
        predict();
        ta = (mode_i == 2'd1) ? "R3" : (mode_i == 2'd2) ? "R4" : (rpt_dst_i ? "R6" : "R1");
        tc = (mode_i == 2'd1) ? "R3" : (mode_i == 2'd2) ? "R4" : "R2";
        te = (mode_i == 2'd1) ? "R3" : (mode_i == 2'd2) ? "R5" : "R2";
        ti = irq_each_i ? "R7" : "R8";
        if (e_err) begin ta = "R10"; tc = "R10"; te = "R10"; ti = "R10"; end
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        chk("R11", "done", 32'(done_o), 32'd1);
        chk("R10", "err", 32'(err_o), 32'(e_err));
        chk(ta, "src_next", src_next_o, e_src);
        chk(ta, "dst_next", dst_next_o, e_dst);
        chk(tc, "cnt_next", 32'(cnt_next_o), 32'(e_cnt));
        chk(e_err ? "R10" : "R5", "blk_next", 32'(blk_next_o), 32'(e_blk));
        chk(tc, "eob", 32'(eob_o), 32'(e_eob));
        chk(te, "eot", 32'(eot_o), 32'(e_eot));
        chk(ti, "irq", 32'(irq_o), 32'(e_irq));
        chk(e_err ? "R10" : "R9", "chain", 32'(chain_o), 32'(e_chain));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] hold_src;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", "done", 32'(done_o), 32'd0);
        chk("R12", "src_next", src_next_o, 32'd0);
        chk("R12", "cnt_next", 32'(cnt_next_o), 32'd0);
        chk("R12", "flags", {26'd0, err_o, eob_o, eot_o, irq_o, chain_o, done_o}, 32'd0);

        // Sweep of modes, sizes, address modes, repeat select and boundary descriptors
        for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
        for (int sa = 0; sa < 4; sa++)
        for (int da = 0; da < 4; da++)
        for (int r = 0; r < 2; r++)
        for (int v = 0; v < 4; v++) begin
            mode_i = 2'(m); usize_i = 2'(s); src_am_i = 2'(sa); dst_am_i = 2'(da);
            rpt_dst_i = r[0];
            unique case (v)
                0: begin src_addr_i = 32'h0000_0000; dst_addr_i = 32'hFFFF_FFFC;
                         cnt_i = 16'd1; blk_i = 16'd1; reload_i = 8'd0;
                         irq_each_i = 1'b0; chain_i = 2'd2; end
                1: begin src_addr_i = 32'h1000_0002; dst_addr_i = 32'h2000_0004;
                         cnt_i = 16'd0; blk_i = 16'd0; reload_i = 8'd7;
                         irq_each_i = 1'b1; chain_i = 2'd1; end
                2: begin src_addr_i = 32'h1000_0001; dst_addr_i = 32'h2000_0000;
                         cnt_i = 16'h0101; blk_i = 16'd2; reload_i = 8'd255;
                         irq_each_i = 1'b0; chain_i = 2'd0; end
                default: begin src_addr_i = 32'hFFFF_FFF8; dst_addr_i = 32'h0000_0008;
                         cnt_i = 16'h0300; blk_i = 16'd1; reload_i = 8'd3;
                         irq_each_i = 1'b1; chain_i = 2'd3; end
            endcase
            step_and_check();
        end

        // R11: no step, outputs hold and done drops
        hold_src = src_next_o;
        @(negedge clk);
        chk("R11", "done idle", 32'(done_o), 32'd0);
        chk("R11", "src hold", src_next_o, hold_src);

        // R5: block run fed back, end of transfer on the fourth unit
        mode_i = 2'd2; usize_i = 2'd2; src_am_i = 2'd1; dst_am_i = 2'd1;
        rpt_dst_i = 1'b1; irq_each_i = 1'b0; chain_i = 2'd2; reload_i = 8'd2;
        src_addr_i = 32'h0000_0100; dst_addr_i = dst_init_i;
        cnt_i = 16'd2; blk_i = 16'd2;
        for (int k = 0; k < 4; k++) begin
            step_and_check();
            chk("R5", "eot position", 32'(eot_o), (k == 3) ? 32'd1 : 32'd0);
            src_addr_i = src_next_o; dst_addr_i = dst_next_o;
            cnt_i = cnt_next_o; blk_i = blk_next_o;
        end

        // R3: repeat run fed back, reload after three units
        mode_i = 2'd1; rpt_dst_i = 1'b0; reload_i = 8'd3; cnt_i = 16'd3;
        src_addr_i = src_init_i; dst_addr_i = 32'h0000_0200; irq_each_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step_and_check();
            chk("R3", "wrap position", 32'(eob_o), (k % 3 == 2) ? 32'd1 : 32'd0);
            src_addr_i = src_next_o; dst_addr_i = dst_next_o; cnt_i = cnt_next_o;
        end

        // R2: normal run fed back from 3
        mode_i = 2'd0; cnt_i = 16'd3; irq_each_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step_and_check();
            chk("R2", "end position", 32'(eot_o), (k == 2) ? 32'd1 : 32'd0);
            src_addr_i = src_next_o; dst_addr_i = dst_next_o; cnt_i = cnt_next_o;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule